// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the PHY-side agent of the two-wire serial management interface. It watches the management clock (MDC) and the shared data line (MDIO), decodes each management frame, and turns matching reads and writes into single-cycle accesses on a simple register-bank port. One instance serves two PHY ports that sit on the same management line. Each port answers to its own 5-bit PHY address.

MDC and MDIO are treated as slow data inputs. They are resynchronised into the system clock domain, so any MDC rate up to 2.5 MHz works as long as each MDC phase lasts several system clocks. After reset, the block waits for one run of 32 preamble ones. From then on it also accepts frames that begin directly with the start pattern, which is preamble suppression. For that reason a read of the status register always returns bit 6 set.

The PHY address register (register 0x19) lives inside the block. At reset each port loads the four strap pins as bits 4:1. Bit 0 is the port number. A management write to that register replaces the whole address of the port that was addressed.

Top module: `mdio_slv`

## Requirements
- R1: In reset and after it, mdio_oe is 0 and rb_we and rb_re are 0. Each port's PHY address is set to {strap_addr, port number}, so with straps 4'b1010 port 0 answers to 0x14 and port 1 to 0x15.
- R2: After reset, no frame is accepted until 32 consecutive ones have been sampled on MDIO. A run of only 31 ones followed by a frame leaves both strobes low and MDIO released.
- R3: Once the preamble has been seen, a frame may start directly with its start pattern. After a frame ends, at least one 1 bit must be sampled before the next start pattern is recognised.
- R4: Bits are sampled on the MDC rising edge, and the frame fields come in this order: start 0 then 1; opcode 1,0 = read or 0,1 = write; PHY address (5 bits, MSB first); register address (5 bits, MSB first); two turnaround bits; 16 data bits (MSB first).
- R5: A matching write raises rb_we for exactly one clock, carrying rb_port, rb_addr and rb_wdata. This happens on the third system clock edge after the MDC rise that samples the 16th data bit, and never earlier.
- R6: A matching read raises rb_port, rb_addr and a one-clock rb_re on the third clock edge after the MDC rise that samples the last register address bit. rb_rdata is taken on the clock after rb_re.
- R7: On a matching read, MDIO is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow, MSB first, each changing just after an MDC rise. MDIO is released after the last data bit.
- R8: A read of register 0x01 returns the bank data with bit 6 (mask 0x0040) forced to 1.
- R9: Register 0x19 is served inside the block. A read returns the port's 5-bit address, zero-extended. A write loads rb_wdata bits 4:0 into that port's address. Neither access raises rb_re or rb_we.
- R10: A frame whose PHY address matches neither port is ignored. MDIO stays released for the whole frame and neither strobe is raised. If both ports hold the same address, port 0 answers.
- R11: A start pattern other than 0,1 or an opcode of 0,0 or 1,1 ends the frame with no strobe. The decoder then waits for a 1 bit, after which a start pattern is accepted without any new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the shared MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable; 0 leaves the line to the pull-up |
| strap_addr | input | 4 | PHY address strap pins, loaded as address bits 4:1 at reset |
| rb_port | output | 1 | Port selected by the current access |
| rb_addr | output | 5 | Register address of the current access |
| rb_wdata | output | 16 | Write data for the register bank |
| rb_we | output | 1 | One-clock write strobe |
| rb_re | output | 1 | One-clock read strobe |
| rb_rdata | input | 16 | Bank read data, valid on the clock after rb_re |

## Verification
Every MDC rise reaches the decoder after two synchroniser stages, so the decoder acts on the third system clock edge after the rise. At that edge mdio_o, mdio_oe, rb_re and rb_we change. The bench holds each MDC phase for 20 clocks. It reads the line in the middle of the low phase, well after the previous rise has taken effect and before the next one. This is the bit the station would sample at the coming rise. The strobes are counted on every clock, and the write count is also read just before the last data bit's rise, which shows that no write is committed early.

// File: rtl/mdio_slv_pkg.sv
// Shared types for the MDIO management slave.
// Assumes: the frame decoder is the only user of the state encoding.
package mdio_slv_pkg;

    // Decoder position within the management frame.
    typedef enum logic [3:0] {
        S_PRE,    // after reset: counting the initial run of preamble ones
        S_IDLE,   // armed: a 0 begins the start pattern
        S_START,  // second start bit expected to be 1
        S_OP,     // two opcode bits
        S_PHY,    // PHY address bits
        S_REG,    // register address bits
        S_TA,     // two turnaround bits
        S_DATA,   // data bits
        S_GAP     // frame over or aborted: waiting for a 1 bit
    } frame_st_e;

endpackage

// File: rtl/mdio_slv_sync.sv
// Brings MDC and MDIO into the system clock domain and flags MDC rising edges.
// Assumes: each MDC phase lasts at least STAGES+1 system clocks, and the line
// idles high (pull-up), which is why the stages reset to 1.
module mdio_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic bit_rise,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_ff;
    logic [STAGES-1:0] mdio_ff;
    logic              mdc_prev;

    // Shift both pins through the synchroniser chains and keep the last MDC level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_ff   <= '1;
            mdio_ff  <= '1;
            mdc_prev <= 1'b1;
        end else begin
            mdc_ff   <= {mdc_ff[STAGES-2:0], mdc};
            mdio_ff  <= {mdio_ff[STAGES-2:0], mdio_i};
            mdc_prev <= mdc_ff[STAGES-1];
        end
    end

    assign bit_rise = mdc_ff[STAGES-1] & ~mdc_prev;
    assign bit_val  = mdio_ff[STAGES-1];

    // R4: a rising-edge flag never lasts two clocks in a row
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise) else $error("MDC rise flag held for two clocks");

endmodule

// File: rtl/mdio_slv_phyad.sv
// Holds one PHY address register per port. Each address loads {straps, port
// number} during reset and can later be replaced by a management write.
// Assumes: the write request is a one-clock pulse from the frame decoder.
module mdio_slv_phyad #(
    parameter int NUM_PORTS = 2,
    parameter int PHY_AW    = 5,
    parameter int PORT_W    = 1,
    parameter int STRAP_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [STRAP_W-1:0]            strap,
    input  logic                          wr,
    input  logic [PORT_W-1:0]             wr_port,
    input  logic [PHY_AW-1:0]             wr_addr,
    output logic [NUM_PORTS*PHY_AW-1:0]   addrs
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [PHY_AW-1:0] a_q;

        // Load straps in reset; take a management write aimed at this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= {strap, PORT_W'(g)};
            end else if (wr && (wr_port == PORT_W'(g))) begin
                a_q <= wr_addr;
            end
        end

        assign addrs[g*PHY_AW +: PHY_AW] = a_q;

        // R1: the low address bits equal the port number right after reset
        p_port_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (a_q[PORT_W-1:0] == PORT_W'(g)))
            else $error("port bit of PHY address wrong after reset");
    end

endmodule

// File: rtl/mdio_slv_fsm.sv
// Frame decoder for the management line. It walks the frame fields on each
// sampled MDC rise, matches the PHY address against every port, issues read
// and write strobes, and drives the turnaround and read data onto MDIO.
// Assumes: bit_rise/bit_val come from the synchroniser; the bank returns
// rb_rdata one clock after rb_re; the address register is served here.
module mdio_slv_fsm
    import mdio_slv_pkg::*;
#(
    parameter int          NUM_PORTS  = 2,
    parameter int          PORT_W     = 1,
    parameter int          PHY_AW     = 5,
    parameter int          REG_AW     = 5,
    parameter int          DATA_W     = 16,
    parameter int          PRE_LEN    = 32,
    parameter int          SUPP_BIT   = 6,
    parameter logic [4:0]  STATUS_REG = 5'h01,
    parameter logic [4:0]  PHYAD_REG  = 5'h19
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_rise,
    input  logic                        bit_val,
    input  logic [NUM_PORTS*PHY_AW-1:0] addrs,
    output logic                        mdio_o,
    output logic                        mdio_oe,
    output logic [PORT_W-1:0]           rb_port,
    output logic [REG_AW-1:0]           rb_addr,
    output logic [DATA_W-1:0]           rb_wdata,
    output logic                        rb_we,
    output logic                        rb_re,
    input  logic [DATA_W-1:0]           rb_rdata,
    output logic                        aw_we
);
    localparam int               CNT_MAX   = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int               CNT_W     = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] PHY_LAST  = CNT_W'(PHY_AW - 1);
    localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(REG_AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] SUPP_MASK = DATA_W'(1) << SUPP_BIT;

    frame_st_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   sh_q;      // incoming field bits
    logic [DATA_W-1:0]   out_sh;    // outgoing read data
    logic                op_rd;     // 1: read frame, 0: write frame
    logic                match_q;
    logic [PORT_W-1:0]   port_q;
    logic [REG_AW-1:0]   reg_q;
    logic                cap_q;     // bank data due this clock
    logic [DATA_W-1:0]   data_now;
    logic [PHY_AW-1:0]   phy_now;
    logic [REG_AW-1:0]   reg_now;
    logic                hit;
    logic [PORT_W-1:0]   hit_port;
    logic                drive;

    assign data_now = {sh_q[DATA_W-2:0], bit_val};
    assign phy_now  = data_now[PHY_AW-1:0];
    assign reg_now  = data_now[REG_AW-1:0];
    assign drive    = match_q && op_rd;

    // Compare the arriving PHY address with every port; the lowest port wins.
    always_comb begin
        hit      = 1'b0;
        hit_port = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (addrs[i*PHY_AW +: PHY_AW] == phy_now) begin
                hit      = 1'b1;
                hit_port = PORT_W'(i);
            end
        end
    end

    // Step through the frame fields on each sampled MDC rise; strobes last one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_PRE;
            cnt      <= '0;
            sh_q     <= '0;
            out_sh   <= '0;
            op_rd    <= 1'b0;
            match_q  <= 1'b0;
            port_q   <= '0;
            reg_q    <= '0;
            cap_q    <= 1'b0;
            mdio_oe  <= 1'b0;
            mdio_o   <= 1'b1;
            rb_re    <= 1'b0;
            rb_we    <= 1'b0;
            aw_we    <= 1'b0;
            rb_wdata <= '0;
        end else begin
            rb_re <= 1'b0;
            rb_we <= 1'b0;
            aw_we <= 1'b0;
            cap_q <= rb_re;
            if (cap_q) begin
                out_sh <= rb_rdata | ((reg_q == STATUS_REG) ? SUPP_MASK : '0);
            end
            if (bit_rise) begin
                case (state)
                    S_PRE: begin
                        if (!bit_val) begin
                            cnt <= '0;
                        end else if (cnt == PRE_LAST) begin
                            cnt   <= '0;
                            state <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_IDLE: begin
                        if (!bit_val) state <= S_START;
                    end
                    S_START: begin
                        cnt   <= '0;
                        state <= bit_val ? S_OP : S_GAP;
                    end
                    S_OP: begin
                        if (cnt == '0) begin
                            op_rd <= bit_val;
                            cnt   <= cnt + 1'b1;
                        end else begin
                            cnt   <= '0;
                            state <= (op_rd != bit_val) ? S_PHY : S_GAP;
                        end
                    end
                    S_PHY: begin
                        sh_q <= data_now;
                        if (cnt == PHY_LAST) begin
                            match_q <= hit;
                            port_q  <= hit_port;
                            cnt     <= '0;
                            state   <= S_REG;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_REG: begin
                        sh_q <= data_now;
                        if (cnt == REG_LAST) begin
                            reg_q <= reg_now;
                            cnt   <= '0;
                            state <= S_TA;
                            if (drive) begin
                                if (reg_now == PHYAD_REG) begin
                                    out_sh <= {{(DATA_W-PHY_AW){1'b0}},
                                               addrs[port_q*PHY_AW +: PHY_AW]};
                                end else begin
                                    rb_re <= 1'b1;
                                end
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_TA: begin
                        if (cnt == '0) begin
                            cnt <= cnt + 1'b1;
                            if (drive) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end
                        end else begin
                            cnt   <= '0;
                            state <= S_DATA;
                            if (drive) begin
                                mdio_o <= out_sh[DATA_W-1];
                                out_sh <= out_sh << 1;
                            end
                        end
                    end
                    S_DATA: begin
                        sh_q <= data_now;
                        if (cnt == DATA_LAST) begin
                            cnt     <= '0;
                            state   <= S_GAP;
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            if (match_q && !op_rd) begin
                                rb_wdata <= data_now;
                                if (reg_q == PHYAD_REG) aw_we <= 1'b1;
                                else                    rb_we <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                            if (drive) begin
                                mdio_o <= out_sh[DATA_W-1];
                                out_sh <= out_sh << 1;
                            end
                        end
                    end
                    S_GAP: begin
                        if (bit_val) state <= S_IDLE;
                    end
                    default: state <= S_PRE;
                endcase
            end
        end
    end

    assign rb_port = port_q;
    assign rb_addr = reg_q;

    // R2: until the preamble completes, the decoder can only stay or become armed
    p_pre_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE) |=> (state == S_PRE || state == S_IDLE))
        else $error("frame decoding began before preamble");
    // R5: write strobe is one clock wide and appears only after the data field
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |=> !rb_we) else $error("write strobe wider than one clock");
    p_we_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> (state == S_GAP)) else $error("write strobe before frame end");
    // R6: read strobe falls inside the turnaround and never with a write
    p_re_in_ta_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_re |-> (state == S_TA && !rb_we)) else $error("read strobe misplaced");
    // R7: the line is driven only during turnaround and data, and low in turnaround
    p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (state == S_TA || state == S_DATA))
        else $error("MDIO driven outside a read response");
    p_ta_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && state == S_TA) |-> !mdio_o)
        else $error("turnaround bit not driven low");
    // R9: address register writes never reach the bank
    p_phyad_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aw_we |-> !rb_we) else $error("address write leaked to bank");

endmodule

// File: rtl/mdio_slv.sv
// Top of the MDIO management slave for a pair of PHY ports on one line.
// Assumes: clk is fast enough that each MDC phase spans at least three
// clocks (2.5 MHz MDC against a clock of tens of MHz or more).
module mdio_slv #(
    parameter int NUM_PORTS   = 2,
    parameter int PHY_AW      = 5,
    parameter int REG_AW      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    parameter int STRAP_W     = PHY_AW - PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic [PORT_W-1:0]  rb_port,
    output logic [REG_AW-1:0]  rb_addr,
    output logic [DATA_W-1:0]  rb_wdata,
    output logic               rb_we,
    output logic               rb_re,
    input  logic [DATA_W-1:0]  rb_rdata
);
    logic                        bit_rise;
    logic                        bit_val;
    logic                        aw_we;
    logic [NUM_PORTS*PHY_AW-1:0] addrs;

    mdio_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .bit_rise (bit_rise),
        .bit_val  (bit_val)
    );

    mdio_slv_phyad #(
        .NUM_PORTS (NUM_PORTS),
        .PHY_AW    (PHY_AW),
        .PORT_W    (PORT_W),
        .STRAP_W   (STRAP_W)
    ) u_phyad (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (strap_addr),
        .wr      (aw_we),
        .wr_port (rb_port),
        .wr_addr (rb_wdata[PHY_AW-1:0]),
        .addrs   (addrs)
    );

    mdio_slv_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .PHY_AW    (PHY_AW),
        .REG_AW    (REG_AW),
        .DATA_W    (DATA_W),
        .PRE_LEN   (PRE_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .bit_val  (bit_val),
        .addrs    (addrs),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rb_port  (rb_port),
        .rb_addr  (rb_addr),
        .rb_wdata (rb_wdata),
        .rb_we    (rb_we),
        .rb_re    (rb_re),
        .rb_rdata (rb_rdata),
        .aw_we    (aw_we)
    );

endmodule

// File: tb/test_mdio_slv.sv
// Directed bench for mdio_slv: one task per scenario, each checking its own results.
module test_mdio_slv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        host = 1'b1;
    logic        line;
    logic        mdio_o, mdio_oe;
    logic [3:0]  strap = 4'b1010;
    logic [0:0]  rb_port;
    logic [4:0]  rb_addr;
    logic [15:0] rb_wdata, rb_rdata;
    logic        rb_we, rb_re;
    logic [15:0] bank [0:1][0:31];
    int          re_cnt, we_cnt, we_pre_last;
    int          n_vec = 0, n_bad = 0;

    always #5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : host;

    mdio_slv i_mdio_slv (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .strap_addr(strap),
        .rb_port(rb_port), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
        .rb_we(rb_we), .rb_re(rb_re), .rb_rdata(rb_rdata)
    );

    // Register bank model: registered read data, write on strobe, strobe counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++)
                for (int r = 0; r < 32; r++) bank[p][r] <= 16'h0000;
            bank[1][1] <= 16'h7800;
            rb_rdata   <= 16'h0000;
            re_cnt     <= 0;
            we_cnt     <= 0;
        end else begin
            if (rb_re) begin
                rb_rdata <= bank[rb_port][rb_addr];
                re_cnt   <= re_cnt + 1;
            end
            if (rb_we) begin
                bank[rb_port][rb_addr] <= rb_wdata;
                we_cnt <= we_cnt + 1;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One MDC bit: host value during low phase, line sampled mid-low, then rise.
    task automatic mbit(input logic b, output logic seen);
        @(negedge clk);
        mdc  = 1'b0;
        host = b;
        repeat (10) @(negedge clk);
        seen = line;
        repeat (10) @(negedge clk);
        mdc = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic ones(input int n);
        logic s;
        repeat (n) mbit(1'b1, s);
    endtask

    task automatic frame(input bit pre, input bit rd, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input int idle,
                         output logic [15:0] rdv, output logic [1:0] ta);
        logic s;
        if (pre) ones(32);
        mbit(1'b0, s);
        mbit(1'b1, s);
        mbit(rd, s);
        mbit(!rd, s);
        for (int i = 4; i >= 0; i--) mbit(phy[i], s);
        for (int i = 4; i >= 0; i--) mbit(ra[i], s);
        mbit(1'b1, ta[1]);
        mbit(rd ? 1'b1 : 1'b0, ta[0]);
        for (int i = 15; i >= 0; i--) begin
            if (i == 0) we_pre_last = we_cnt;
            mbit(rd ? 1'b1 : wd[i], rdv[i]);
        end
        ones(idle);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "oe in reset", {31'b0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "oe after reset", {31'b0, mdio_oe}, 32'd0);
        chk("R1", "strobes after reset", {30'b0, rb_re, rb_we}, 32'd0);
    endtask

    task automatic t_preamble_gate();
        logic [15:0] d; logic [1:0] ta;
        ones(31);
        frame(1'b0, 1'b1, 5'h14, 5'h05, 16'h0, 1, d, ta);
        chk("R2", "31-one read data line", {16'b0, d}, 32'h0000FFFF);
        chk("R2", "31-one read turnaround", {30'b0, ta}, 32'd3);
        chk("R2", "31-one read strobes", re_cnt, 0);
        frame(1'b0, 1'b0, 5'h14, 5'h05, 16'h1111, 1, d, ta);
        chk("R2", "unpreambled write count", we_cnt, 0);
        chk("R2", "unpreambled write bank", {16'b0, bank[0][5]}, 32'h0);
    endtask

    task automatic t_write_read();
        logic [15:0] d; logic [1:0] ta;
        frame(1'b1, 1'b0, 5'h14, 5'h05, 16'hA5C3, 1, d, ta);
        chk("R5", "no write before last data rise", we_pre_last, 0);
        chk("R5", "write count", we_cnt, 1);
        chk("R4", "bank port0 reg5", {16'b0, bank[0][5]}, 32'h0000A5C3);
        frame(1'b0, 1'b1, 5'h14, 5'h05, 16'h0, 1, d, ta);
        chk("R3", "read without preamble", {16'b0, d}, 32'h0000A5C3);
        chk("R7", "turnaround released then 0", {30'b0, ta}, 32'd2);
        chk("R6", "read strobe count", re_cnt, 1);
        chk("R7", "line released after read", {31'b0, mdio_oe}, 32'd0);
        frame(1'b0, 1'b0, 5'h15, 5'h05, 16'h1234, 1, d, ta);
        frame(1'b0, 1'b1, 5'h15, 5'h05, 16'h0, 1, d, ta);
        chk("R6", "port1 reg5 read", {16'b0, d}, 32'h00001234);
        frame(1'b0, 1'b1, 5'h14, 5'h05, 16'h0, 1, d, ta);
        chk("R4", "port0 reg5 kept", {16'b0, d}, 32'h0000A5C3);
    endtask

    task automatic t_status();
        logic [15:0] d; logic [1:0] ta;
        frame(1'b0, 1'b1, 5'h15, 5'h01, 16'h0, 1, d, ta);
        chk("R8", "port1 status bit6 forced", {16'b0, d}, 32'h00007840);
        frame(1'b0, 1'b1, 5'h14, 5'h01, 16'h0, 1, d, ta);
        chk("R8", "port0 status bit6 only", {16'b0, d}, 32'h00000040);
    endtask

    task automatic t_phyad_read();
        logic [15:0] d; logic [1:0] ta; int r0;
        r0 = re_cnt;
        frame(1'b0, 1'b1, 5'h14, 5'h19, 16'h0, 1, d, ta);
        chk("R1", "port0 address from straps", {16'b0, d}, 32'h00000014);
        frame(1'b0, 1'b1, 5'h15, 5'h19, 16'h0, 1, d, ta);
        chk("R1", "port1 address from straps", {16'b0, d}, 32'h00000015);
        chk("R9", "address read no bank strobe", re_cnt, r0);
    endtask

    task automatic t_gap();
        logic [15:0] d; logic [1:0] ta; int r0, w0;
        r0 = re_cnt; w0 = we_cnt;
        frame(1'b0, 1'b0, 5'h14, 5'h06, 16'h0F0F, 0, d, ta);
        frame(1'b0, 1'b1, 5'h14, 5'h05, 16'h0, 1, d, ta);
        chk("R3", "back-to-back read ignored", {16'b0, d}, 32'h0000FFFF);
        chk("R3", "back-to-back read no strobe", re_cnt, r0);
        chk("R3", "first frame still written", we_cnt, w0 + 1);
        chk("R3", "bank port0 reg6", {16'b0, bank[0][6]}, 32'h00000F0F);
    endtask

    task automatic t_mismatch();
        logic [15:0] d; logic [1:0] ta; int r0, w0;
        r0 = re_cnt; w0 = we_cnt;
        frame(1'b1, 1'b0, 5'h03, 5'h05, 16'hDEAD, 1, d, ta);
        frame(1'b0, 1'b1, 5'h03, 5'h05, 16'h0, 1, d, ta);
        chk("R10", "foreign read line", {14'b0, ta, d}, 32'h0003FFFF);
        chk("R10", "foreign strobes", re_cnt + we_cnt, r0 + w0);
        chk("R10", "banks untouched", {bank[0][5], bank[1][5]}, 32'hA5C31234);
    endtask

    task automatic t_invalid();
        logic [15:0] d; logic [1:0] ta; logic s; int r0, w0;
        r0 = re_cnt; w0 = we_cnt;
        ones(32);
        mbit(1'b0, s); mbit(1'b0, s);
        ones(40);
        mbit(1'b0, s); mbit(1'b1, s); mbit(1'b1, s); mbit(1'b1, s);
        ones(40);
        chk("R11", "bad start/opcode strobes", re_cnt + we_cnt, r0 + w0);
        frame(1'b0, 1'b1, 5'h14, 5'h05, 16'h0, 1, d, ta);
        chk("R11", "next frame accepted", {16'b0, d}, 32'h0000A5C3);
    endtask

    task automatic t_rewrite();
        logic [15:0] d; logic [1:0] ta; int r0, w0;
        w0 = we_cnt;
        frame(1'b0, 1'b0, 5'h15, 5'h19, 16'h0007, 1, d, ta);
        chk("R9", "address write no bank strobe", we_cnt, w0);
        frame(1'b0, 1'b1, 5'h07, 5'h19, 16'h0, 1, d, ta);
        chk("R9", "new address readback", {16'b0, d}, 32'h00000007);
        r0 = re_cnt;
        frame(1'b0, 1'b1, 5'h15, 5'h05, 16'h0, 1, d, ta);
        chk("R10", "old address ignored", {16'b0, d}, 32'h0000FFFF);
        chk("R10", "old address no strobe", re_cnt, r0);
        frame(1'b0, 1'b1, 5'h07, 5'h05, 16'h0, 1, d, ta);
        chk("R9", "port1 at new address", {16'b0, d}, 32'h00001234);
    endtask

    initial begin
        t_reset();
        t_preamble_gate();
        t_write_read();
        t_status();
        t_phyad_read();
        t_gap();
        t_mismatch();
        t_invalid();
        t_rewrite();
        finish_run();
    end

endmodule